// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block keeps an asynchronous-strobe DRAM alive. It runs the start-up wake-up sequence, then keeps every one of the 512 rows refreshed. It sits beside the access controller and shares the DRAM strobes and address pins with it through a request/grant pair. The strobes and address it drives mean something only while the grant is held. While it does not own the bus, they rest at their idle levels: RAS and both CAS lines high, address zero.

After reset the sequencer waits a long, parameterised pause. It then asks for the bus and issues a fixed number of RAS-containing wake-up cycles. Only after that does it raise `init_done`, which is the signal that lets host access begin. From then on, a distributed timer makes one refresh owed every `TICK_CYCLES` clocks. Owed refreshes pile up in a bounded counter while the bus is busy elsewhere, and are issued back to back once the grant arrives.

Two refresh styles are offered, chosen per cycle by `ras_only_mode`. In the first, CAS is brought low ahead of RAS and the DRAM uses its own row counter, so the address does not matter. In the second, the sequencer drives the row from its own 9-bit counter and pulses RAS with both CAS lines held high.

Top module: `dram_refresh_seq`

## Requirements
- R1: From reset until `PAUSE_CYCLES` clock edges after reset release, `bus_req` and `init_done` stay low and `ras_n`, `ucas_n`, `lcas_n` stay high.
- R2: After the pause the block requests the bus and completes exactly `WAKE_CYCLES` RAS pulses. `init_done` then rises and stays high until the next reset.
- R3: RAS or CAS is driven low only while `bus_gnt` is high. A cycle starts only with `bus_gnt` high, and `bus_req` stays high until that cycle has ended.
- R4: With `ras_only_mode` = 0 when a cycle starts (CAS-before-RAS style), both CAS lines fall at least `LEAD_CYCLES` clocks before RAS falls and stay low while RAS is low. `addr` is 0 throughout.
- R5: With `ras_only_mode` = 1 when a cycle starts (RAS-only style), both CAS lines stay high, and `addr` carries the row counter value unchanged from the lead phase until RAS rises.
- R6: The row counter is `ROW_W` bits wide and is 0 after reset. It advances by one at the end of each RAS-only cycle, wraps from 511 to 0, and is not moved by CAS-before-RAS cycles.
- R7: Once `init_done` is high, one refresh becomes owed every `TICK_CYCLES` clocks, and `bus_req` is high whenever at least one refresh is owed.
- R8: The owed count saturates at `MAX_DEBT`. Once granted, owed refreshes are issued back to back, and `bus_req` falls when the count reaches zero.
- R9: `ucas_n` and `lcas_n` are identical on every cycle.
- R10: Each RAS low pulse lasts exactly `ACTIVE_CYCLES` clocks. Between two pulses RAS stays high for at least `LEAD_CYCLES + PRECH_CYCLES` clocks.
- R11: If `bus_gnt` is high while `bus_req` is low, then on the next clock RAS and both CAS lines are high and `addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ras_only_mode | input | 1 | Refresh style for the next cycle: 0 = CAS-before-RAS, 1 = RAS-only |
| bus_gnt | input | 1 | Grant from the arbiter; must stay high while `bus_req` is high once given |
| bus_req | output | 1 | Request for the DRAM bus |
| ras_n | output | 1 | Row strobe, active low |
| ucas_n | output | 1 | Upper byte column strobe, active low |
| lcas_n | output | 1 | Lower byte column strobe, active low |
| addr | output | ROW_W | Row address for RAS-only refresh, otherwise 0 |
| init_done | output | 1 | High once the wake-up sequence has completed |

## Verification
The bound checker watches, on every cycle, the quiet pause phase, the CAS pairing, strobes only under grant, CAS leading RAS in one style and staying high in the other, the row counter stepping by one with wrap, the exact RAS width, and the cap on owed refreshes. Some behaviour can only be shown by the bench's scenarios: the exact count of wake-up pulses before `init_done`, the long-run refresh rate, the size of a burst after a withheld grant, and the row sequence across a full wrap with a CAS-before-RAS stretch between two RAS-only stretches. A reset in the middle of operation, followed by a second wake-up, is also covered only by the bench.

// File: rtl/dref_pkg.sv
// Shared types for the DRAM refresh and power-up sequencer.
// Assumes nothing beyond IEEE 1800-2017 enums.
package dref_pkg;

    // Top-level life cycle of the sequencer.
    typedef enum logic [1:0] {
        PH_PAUSE = 2'd0,   // long quiet wait after reset
        PH_WAKE  = 2'd1,   // issuing wake-up RAS cycles
        PH_RUN   = 2'd2    // normal distributed refresh
    } phase_e;

    // Phases of one refresh cycle on the DRAM pins.
    typedef enum logic [1:0] {
        CY_IDLE   = 2'd0,  // strobes high, bus may be released
        CY_LEAD   = 2'd1,  // CAS low (CBR) or row on address (RAS-only)
        CY_ACTIVE = 2'd2,  // RAS low
        CY_PRECH  = 2'd3   // all strobes high, RAS precharge
    } cycle_e;

endpackage

// File: rtl/dref_interval_timer.sv
// Counts LIMIT enabled clocks. Periodic variant: a one-clock pulse on
// 'fire' each time LIMIT clocks elapse. One-shot variant: 'fire' goes high
// after LIMIT clocks and stays high until reset.
// Assumes LIMIT >= 1; counting halts while 'en' is low.
module dref_interval_timer #(
    parameter int LIMIT    = 16,
    parameter bit ONE_SHOT = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic fire
);

    localparam int CNT_W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             run;
    logic             wrap;

    assign run  = en && !(ONE_SHOT && fire);
    assign wrap = run && (cnt_q == LAST);

    // Free-running count of enabled clocks, cleared at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= wrap ? '0 : cnt_q + CNT_W'(1);
        end
    end

    generate
        if (ONE_SHOT) begin : g_once
            logic hit_q;
            // Sticky flag set when the limit is first reached.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    hit_q <= 1'b0;
                end else if (wrap) begin
                    hit_q <= 1'b1;
                end
            end
            assign fire = hit_q;
        end else begin : g_loop
            logic pulse_q;
            // One-clock pulse per elapsed period.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pulse_q <= 1'b0;
                end else begin
                    pulse_q <= wrap;
                end
            end
            assign fire = pulse_q;
        end
    endgenerate

endmodule

// File: rtl/dref_debt_counter.sv
// Tracks how many refreshes are owed. 'add' raises the count, 'take'
// lowers it. The count saturates at MAX_DEBT, so further ticks are lost.
// Assumes 'take' is only raised while the count is non-zero.
module dref_debt_counter #(
    parameter int MAX_DEBT = 4
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             add,
    input  logic                             take,
    output logic [$clog2(MAX_DEBT+1)-1:0]    owed
);

    localparam int DW = $clog2(MAX_DEBT + 1);
    localparam logic [DW-1:0] CAP = DW'(MAX_DEBT);

    // Saturating up/down count of owed refreshes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owed <= '0;
        end else if (add && !take && (owed != CAP)) begin
            owed <= owed + DW'(1);
        end else if (take && !add && (owed != '0)) begin
            owed <= owed - DW'(1);
        end
    end

endmodule

// File: rtl/dref_cycle_gen.sv
// Generates one refresh cycle on the DRAM strobes per 'start'. The style is
// latched at start: CAS-before-RAS (CAS leads, address 0) or RAS-only
// (row counter on the address, CAS high). The row counter advances at the
// end of each RAS-only cycle. Strobe and address outputs are registered,
// decoded from the next state so they change cleanly on the clock.
// Assumes 'start' is only raised while 'busy' is low.
module dref_cycle_gen
    import dref_pkg::*;
#(
    parameter int ROW_W         = 9,
    parameter int LEAD_CYCLES   = 1,
    parameter int ACTIVE_CYCLES = 4,
    parameter int PRECH_CYCLES  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             ras_only_sel,
    output logic             busy,
    output logic             done,
    output logic             ras_n,
    output logic             cas_n,
    output logic [ROW_W-1:0] addr,
    output logic             style_q,
    output logic [ROW_W-1:0] row_q
);

    localparam int LONGEST_A = (LEAD_CYCLES > ACTIVE_CYCLES) ? LEAD_CYCLES : ACTIVE_CYCLES;
    localparam int LONGEST   = (LONGEST_A > PRECH_CYCLES) ? LONGEST_A : PRECH_CYCLES;
    localparam int PH_W      = $clog2(LONGEST + 1);
    localparam logic [PH_W-1:0] LEAD_LAST = PH_W'(LEAD_CYCLES - 1);
    localparam logic [PH_W-1:0] ACT_LAST  = PH_W'(ACTIVE_CYCLES - 1);
    localparam logic [PH_W-1:0] PRE_LAST  = PH_W'(PRECH_CYCLES - 1);

    cycle_e           state_q, state_d;
    logic [PH_W-1:0]  cnt_q, cnt_d;
    logic [ROW_W-1:0] row_d;
    logic             style_d;
    logic             ras_d, cas_d;
    logic [ROW_W-1:0] addr_d;
    logic             strobing_d;

    // Next-state, phase counter and row counter decisions.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q + PH_W'(1);
        row_d   = row_q;
        style_d = style_q;
        done    = 1'b0;
        case (state_q)
            CY_IDLE: begin
                cnt_d = '0;
                if (start) begin
                    state_d = CY_LEAD;
                    style_d = ras_only_sel;
                end
            end
            CY_LEAD: begin
                if (cnt_q == LEAD_LAST) begin
                    state_d = CY_ACTIVE;
                    cnt_d   = '0;
                end
            end
            CY_ACTIVE: begin
                if (cnt_q == ACT_LAST) begin
                    state_d = CY_PRECH;
                    cnt_d   = '0;
                    if (style_q) begin
                        row_d = row_q + ROW_W'(1);
                    end
                end
            end
            CY_PRECH: begin
                if (cnt_q == PRE_LAST) begin
                    state_d = CY_IDLE;
                    cnt_d   = '0;
                    done    = 1'b1;
                end
            end
            default: begin
                state_d = CY_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // Pin levels that belong to the next state.
    always_comb begin
        strobing_d = (state_d == CY_LEAD) || (state_d == CY_ACTIVE);
        ras_d      = (state_d != CY_ACTIVE);
        cas_d      = !(strobing_d && !style_d);
        addr_d     = (strobing_d && style_d) ? row_d : '0;
    end

    // State, counters and registered pin drivers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CY_IDLE;
            cnt_q   <= '0;
            row_q   <= '0;
            style_q <= 1'b0;
            ras_n   <= 1'b1;
            cas_n   <= 1'b1;
            addr    <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            row_q   <= row_d;
            style_q <= style_d;
            ras_n   <= ras_d;
            cas_n   <= cas_d;
            addr    <= addr_d;
        end
    end

    assign busy = (state_q != CY_IDLE);

endmodule

// File: rtl/dram_refresh_seq.sv
// DRAM refresh and power-up sequencer. After reset it holds the bus quiet
// for PAUSE_CYCLES, then issues WAKE_CYCLES RAS cycles, then raises
// init_done and refreshes one row every TICK_CYCLES clocks. Missed
// refreshes are counted up to MAX_DEBT and issued back to back once granted.
// Assumes the arbiter keeps bus_gnt high for as long as bus_req is high
// once it has granted; strobes are only driven low under grant.
module dram_refresh_seq
    import dref_pkg::*;
#(
    parameter int ROW_W         = 9,
    parameter int TICK_CYCLES   = 781,
    parameter int PAUSE_CYCLES  = 10_000_000,
    parameter int WAKE_CYCLES   = 8,
    parameter int MAX_DEBT      = 4,
    parameter int LEAD_CYCLES   = 1,
    parameter int ACTIVE_CYCLES = 4,
    parameter int PRECH_CYCLES  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ras_only_mode,
    input  logic             bus_gnt,
    output logic             bus_req,
    output logic             ras_n,
    output logic             ucas_n,
    output logic             lcas_n,
    output logic [ROW_W-1:0] addr,
    output logic             init_done
);

    localparam int DEBT_W = $clog2(MAX_DEBT + 1);
    localparam int WK_W   = $clog2(WAKE_CYCLES + 1);
    localparam logic [WK_W-1:0] WAKE_LAST = WK_W'(WAKE_CYCLES - 1);

    phase_e            phase_q;
    logic [WK_W-1:0]   wake_cnt_q;
    logic              pause_over;
    logic              tick;
    logic [DEBT_W-1:0] owed;
    logic              need;
    logic              start;
    logic              take;
    logic              cyc_busy;
    logic              cyc_done;
    logic              cas_n_i;
    logic              style_q;
    logic [ROW_W-1:0]  row_q;

    // One-shot power-up pause.
    dref_interval_timer #(
        .LIMIT    (PAUSE_CYCLES),
        .ONE_SHOT (1'b1)
    ) u_pause (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (phase_q == PH_PAUSE),
        .fire  (pause_over)
    );

    // Distributed refresh tick, running only after initialisation.
    dref_interval_timer #(
        .LIMIT    (TICK_CYCLES),
        .ONE_SHOT (1'b0)
    ) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (phase_q == PH_RUN),
        .fire  (tick)
    );

    // Count of refreshes owed but not yet issued.
    dref_debt_counter #(
        .MAX_DEBT (MAX_DEBT)
    ) u_debt (
        .clk   (clk),
        .rst_n (rst_n),
        .add   (tick),
        .take  (take),
        .owed  (owed)
    );

    // Strobe waveform generator with the RAS-only row counter.
    dref_cycle_gen #(
        .ROW_W         (ROW_W),
        .LEAD_CYCLES   (LEAD_CYCLES),
        .ACTIVE_CYCLES (ACTIVE_CYCLES),
        .PRECH_CYCLES  (PRECH_CYCLES)
    ) u_cycle (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .ras_only_sel (ras_only_mode),
        .busy         (cyc_busy),
        .done         (cyc_done),
        .ras_n        (ras_n),
        .cas_n        (cas_n_i),
        .addr         (addr),
        .style_q      (style_q),
        .row_q        (row_q)
    );

    // Work is pending during wake-up or while refreshes are owed.
    always_comb begin
        need  = (phase_q == PH_WAKE) || ((phase_q == PH_RUN) && (owed != '0));
        start = need && bus_gnt && !cyc_busy;
        take  = cyc_done && (phase_q == PH_RUN);
    end

    // Life-cycle phase and wake-up cycle count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q    <= PH_PAUSE;
            wake_cnt_q <= '0;
        end else begin
            case (phase_q)
                PH_PAUSE: begin
                    if (pause_over) begin
                        phase_q <= PH_WAKE;
                    end
                end
                PH_WAKE: begin
                    if (cyc_done) begin
                        if (wake_cnt_q == WAKE_LAST) begin
                            phase_q <= PH_RUN;
                        end else begin
                            wake_cnt_q <= wake_cnt_q + WK_W'(1);
                        end
                    end
                end
                default: begin
                    phase_q <= PH_RUN;
                end
            endcase
        end
    end

    assign bus_req   = need || cyc_busy;
    assign ucas_n    = cas_n_i;
    assign lcas_n    = cas_n_i;
    assign init_done = (phase_q == PH_RUN);

endmodule

// File: rtl/dref_checker.sv
// Cycle-by-cycle properties of the refresh sequencer, bound to the top.
// Assumes the environment holds bus_gnt while bus_req is high.
module dref_checker
    import dref_pkg::*;
#(
    parameter int ROW_W         = 9,
    parameter int MAX_DEBT      = 4,
    parameter int ACTIVE_CYCLES = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bus_gnt,
    input  logic                          bus_req,
    input  logic                          ras_n,
    input  logic                          ucas_n,
    input  logic                          lcas_n,
    input  logic                          init_done,
    input  phase_e                        phase_q,
    input  logic                          style_q,
    input  logic [ROW_W-1:0]              row_q,
    input  logic [$clog2(MAX_DEBT+1)-1:0] owed
);

    localparam int DW = $clog2(MAX_DEBT + 1);
    localparam logic [DW-1:0] CAP = DW'(MAX_DEBT);

    int low_run;

    // Length of the current RAS low stretch, in clocks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_run <= 0;
        end else begin
            low_run <= ras_n ? 0 : low_run + 1;
        end
    end

    a_r1_quiet_pause: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_PAUSE) |-> (ras_n && ucas_n && !bus_req && !init_done));

    a_r2_init_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    a_r3_strobe_granted: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n || !ucas_n) |-> bus_gnt);

    a_r4_cas_leads: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n) && !style_q) |-> (!$past(ucas_n) && !ucas_n));

    a_r5_cas_parked: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n && style_q) |-> (ucas_n && lcas_n));

    a_r6_row_step: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ras_n) && style_q) |-> (row_q == ROW_W'($past(row_q) + ROW_W'(1))));

    a_r6_row_kept: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ras_n) && !style_q) |-> $stable(row_q));

    a_r8_debt_cap: assert property (@(posedge clk) disable iff (!rst_n)
        owed <= CAP);

    a_r9_cas_pair: assert property (@(posedge clk) disable iff (!rst_n)
        ucas_n == lcas_n);

    a_r10_ras_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> (low_run == ACTIVE_CYCLES));

endmodule

bind dram_refresh_seq dref_checker #(
    .ROW_W         (ROW_W),
    .MAX_DEBT      (MAX_DEBT),
    .ACTIVE_CYCLES (ACTIVE_CYCLES)
) u_dref_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_gnt   (bus_gnt),
    .bus_req   (bus_req),
    .ras_n     (ras_n),
    .ucas_n    (ucas_n),
    .lcas_n    (lcas_n),
    .init_done (init_done),
    .phase_q   (phase_q),
    .style_q   (style_q),
    .row_q     (row_q),
    .owed      (owed)
);

// File: tb/test_dram_refresh_seq.sv
`timescale 1ns/1ps
module test_dram_refresh_seq;

    localparam int P_ROW   = 9;
    localparam int P_TICK  = 40;
    localparam int P_PAUSE = 60;
    localparam int P_WAKE  = 8;
    localparam int P_DEBT  = 3;
    localparam int P_LEAD  = 2;
    localparam int P_ACT   = 3;
    localparam int P_PRE   = 2;
    localparam int N_ROWS  = 1 << P_ROW;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             ras_only_mode;
    logic             bus_gnt;
    logic             bus_req;
    logic             ras_n;
    logic             ucas_n;
    logic             lcas_n;
    logic [P_ROW-1:0] addr;
    logic             init_done;

    int n_checks = 0;
    int n_fail   = 0;
    bit gnt_block = 1'b0;

    // Monitor state.
    bit prev_ras = 1'b1, prev_req = 1'b0, prev_gnt = 1'b0;
    int ras_low_run = 0, ras_high_run = 0, cas_low_run = 0;
    int pulse_cnt = 0, exp_row = 0;
    int viol_r3 = 0, viol_r4 = 0, viol_r5 = 0, viol_r9 = 0, viol_r11 = 0;
    bit wrap_seen = 1'b0;
    logic [P_ROW-1:0] held_addr = '0;

    always #10 clk = ~clk;

    dram_refresh_seq #(
        .ROW_W         (P_ROW),
        .TICK_CYCLES   (P_TICK),
        .PAUSE_CYCLES  (P_PAUSE),
        .WAKE_CYCLES   (P_WAKE),
        .MAX_DEBT      (P_DEBT),
        .LEAD_CYCLES   (P_LEAD),
        .ACTIVE_CYCLES (P_ACT),
        .PRECH_CYCLES  (P_PRE)
    ) i_dram_refresh_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .ras_only_mode (ras_only_mode),
        .bus_gnt       (bus_gnt),
        .bus_req       (bus_req),
        .ras_n         (ras_n),
        .ucas_n        (ucas_n),
        .lcas_n        (lcas_n),
        .addr          (addr),
        .init_done     (init_done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int next_row(input int r);
        return (r + 1) % N_ROWS;
    endfunction

    function automatic bit in_window(input int v, input int lo, input int hi);
        return (v >= lo) && (v <= hi);
    endfunction

    task automatic sample();
        @(posedge clk);
        #6;
    endtask

    // Arbiter model: grants after a random delay, holds while requested,
    // toggles the grant at random while nothing is requested.
    initial begin
        int gdelay;
        gdelay  = 0;
        bus_gnt = 1'b0;
        forever begin
            @(negedge clk);
            if (gnt_block) begin
                bus_gnt = 1'b0;
            end else if (bus_req) begin
                if (!bus_gnt) begin
                    if (gdelay == 0) begin
                        bus_gnt = 1'b1;
                        gdelay  = $urandom_range(0, 3);
                    end else begin
                        gdelay--;
                    end
                end
            end else begin
                bus_gnt = ($urandom_range(0, 3) == 0);
            end
        end
    end

    // Pin monitor, sampling mid-cycle.
    always @(posedge clk) begin
        #5;
        if (!rst_n) begin
            prev_ras = 1'b1; prev_req = 1'b0; prev_gnt = 1'b0;
            ras_low_run = 0; ras_high_run = 0; cas_low_run = 0;
            pulse_cnt = 0; exp_row = 0; held_addr = '0;
        end else begin
            if (ucas_n !== lcas_n) viol_r9++;
            if ((!ras_n || !ucas_n) && !bus_gnt) viol_r3++;
            if (prev_gnt && !prev_req && (!ras_n || !ucas_n || addr != '0)) viol_r11++;
            if (prev_ras && !ras_n) begin
                pulse_cnt++;
                held_addr = addr;
                if (pulse_cnt > 1)
                    check(ras_high_run >= P_LEAD + P_PRE, "R10 RAS high between pulses", ras_high_run, P_LEAD + P_PRE);
                if (ras_only_mode) begin
                    check(ucas_n && lcas_n, "R5 CAS high at RAS fall", int'(ucas_n), 1);
                    check(int'(addr) == exp_row, "R6 row address sequence", int'(addr), exp_row);
                    if (exp_row == N_ROWS - 1) wrap_seen = 1'b1;
                    exp_row = next_row(exp_row);
                end else begin
                    check(cas_low_run >= P_LEAD && !ucas_n, "R4 CAS leads RAS", cas_low_run, P_LEAD);
                    check(addr == '0, "R4 address zero", int'(addr), 0);
                end
            end
            if (!ras_n) begin
                if (ras_only_mode) begin
                    if (!ucas_n || addr != held_addr) viol_r5++;
                end else if (ucas_n) begin
                    viol_r4++;
                end
            end
            if (!prev_ras && ras_n)
                check(ras_low_run == P_ACT, "R10 RAS low width", ras_low_run, P_ACT);
            ras_low_run  = ras_n ? 0 : ras_low_run + 1;
            ras_high_run = ras_n ? ras_high_run + 1 : 0;
            cas_low_run  = ucas_n ? 0 : cas_low_run + 1;
            prev_ras = ras_n; prev_req = bus_req; prev_gnt = bus_gnt;
        end
    end

    task automatic quiesce_grant();
        int guard;
        guard = 0;
        gnt_block = 1'b0;
        do begin
            sample();
            guard++;
        end while ((bus_req || !ras_n || !ucas_n) && guard < 2000);
        gnt_block = 1'b1;
    endtask

    task automatic wait_init(output int cycles);
        cycles = 0;
        while (!init_done && cycles < 5000) begin
            sample();
            cycles++;
        end
    endtask

    task automatic wait_req_low();
        int guard;
        guard = 0;
        do begin
            sample();
            guard++;
        end while (bus_req && guard < 2000);
    endtask

    task automatic backlog(input int hold_ticks);
        int base;
        int burst;
        quiesce_grant();
        base = pulse_cnt;
        repeat (hold_ticks * P_TICK) sample();
        check(bus_req == 1'b1, "R7 request held while refresh owed", int'(bus_req), 1);
        check(pulse_cnt == base, "R3 no cycle without grant", pulse_cnt - base, 0);
        base = pulse_cnt;
        gnt_block = 1'b0;
        wait_req_low();
        burst = pulse_cnt - base;
        check(in_window(burst, P_DEBT, P_DEBT + 1), "R8 saturated burst size", burst, P_DEBT);
    endtask

    initial begin
        int cyc;
        int base;
        int bad;
        void'($urandom(32'd4711));
        rst_n = 1'b0;
        ras_only_mode = 1'b0;
        repeat (4) @(posedge clk);
        #6;
        check(ras_n && ucas_n && lcas_n, "R1 strobes idle in reset", int'(ras_n), 1);
        check(!bus_req && !init_done, "R1 no request in reset", int'(bus_req), 0);
        @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: quiet pause.
        bad = 0;
        for (int k = 0; k < P_PAUSE; k++) begin
            sample();
            if (bus_req || !ras_n || !ucas_n || init_done) bad++;
        end
        check(bad == 0, "R1 quiet during pause", bad, 0);

        // R2: wake-up in CAS-before-RAS style.
        wait_init(cyc);
        check(init_done == 1'b1, "R2 init_done raised", int'(init_done), 1);
        check(pulse_cnt == P_WAKE, "R2 wake pulse count", pulse_cnt, P_WAKE);

        // R7: steady refresh rate.
        base = pulse_cnt;
        repeat (40 * P_TICK) sample();
        check(in_window(pulse_cnt - base, 39, 41), "R7 refresh rate", pulse_cnt - base, 40);

        // R8: withheld grant, random hold lengths.
        backlog(4 + $urandom_range(0, 4));
        backlog(6 + $urandom_range(0, 6));

        // R5, R6: RAS-only stretch through a full wrap.
        quiesce_grant();
        ras_only_mode = 1'b1;
        gnt_block = 1'b0;
        cyc = 0;
        while (!wrap_seen && cyc < 40000) begin
            sample();
            cyc++;
        end
        check(wrap_seen, "R6 row counter wrapped", int'(wrap_seen), 1);
        repeat (10 * P_TICK) sample();

        // R6: CBR stretch must leave the row counter alone.
        quiesce_grant();
        ras_only_mode = 1'b0;
        gnt_block = 1'b0;
        repeat (6 * P_TICK) sample();
        quiesce_grant();
        ras_only_mode = 1'b1;
        gnt_block = 1'b0;
        base = pulse_cnt;
        repeat (6 * P_TICK) sample();
        check(pulse_cnt > base, "R6 RAS-only resumes after CBR", pulse_cnt - base, 6);

        // Reset during operation, wake-up again in RAS-only style.
        repeat ($urandom_range(3, 30)) @(posedge clk);
        #1 rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #6;
        check(ras_n && ucas_n && !init_done && !bus_req, "R1 idle after mid-run reset", int'(init_done), 0);
        @(posedge clk);
        #1 rst_n = 1'b1;
        wait_init(cyc);
        check(cyc > P_PAUSE, "R1 pause repeated after reset", cyc, P_PAUSE);
        check(pulse_cnt == P_WAKE, "R2 wake pulse count after reset", pulse_cnt, P_WAKE);
        check(exp_row == P_WAKE, "R6 rows after RAS-only wake", exp_row, P_WAKE);
        repeat (5 * P_TICK) sample();
        check(init_done == 1'b1, "R2 init_done stays high", int'(init_done), 1);

        // Per-cycle invariants gathered by the monitor.
        check(viol_r3 == 0, "R3 strobes only under grant", viol_r3, 0);
        check(viol_r4 == 0, "R4 CAS low throughout RAS", viol_r4, 0);
        check(viol_r5 == 0, "R5 CAS high and address held", viol_r5, 0);
        check(viol_r9 == 0, "R9 CAS lines paired", viol_r9, 0);
        check(viol_r11 == 0, "R11 idle grant starts nothing", viol_r11, 0);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog R2/R7 progress: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule